// File: doc/BRIEF.md
# Operand-Width Sleep Controller for a Gated Multiplier

This block decides, cycle by cycle, which parts of a WIDTH x WIDTH multiplier array may be switched off. The array is split into a low part that is always powered and two gateable parts. The mid domain computes the cross terms (low half of one operand times high half of the other). The hi domain computes the high-half by high-half term. The block looks at the upper half of each incoming operand. When an operation arrives that does not need a domain, the block isolates that domain and then puts it to sleep. While a domain is isolated, its contribution to the sum is forced to zero. This keeps the product exact for narrow operands.

A domain is never woken before it has slept for a minimum number of cycles. Waking it costs a fixed number of cycles. While a domain that the present operand needs is not fully awake, the block deasserts `ready`. The operation is then held at the input until that domain is available. Accepted operations return their full product one cycle after acceptance. The power switch itself lies outside the block; the block only drives the sleep and isolation controls.

Top module: `opgate_ctrl`

## Requirements
- R1: After reset, `sleep_hi`, `sleep_mid`, `iso_hi`, `iso_mid` and `out_valid` are low, `product` is zero and `ready` is high while no operation is offered.
- R2: An operand is narrow when its bits [WIDTH-1:WIDTH/2] are all zero. An accepted operation with both operands narrow sends both domains to sleep. One with exactly one narrow operand sends only the hi domain to sleep. One with no narrow operand sends neither.
- R3: On entry to sleep, the domain's isolation output rises exactly one cycle before its sleep output rises, and sleep never rises in the same cycle as isolation.
- R4: Once a domain's sleep output has risen, it stays high for at least MIN_SLEEP (default 4) consecutive cycles, even if an operation needing that domain is waiting.
- R5: After a domain's sleep output falls, its isolation output stays high for WAKE_CYC (default 3) cycles plus one more cycle, then falls.
- R6: While `in_valid` is high and a domain needed by the offered operands has its isolation output high, `ready` is low and the operation is not accepted.
- R7: One cycle after an accepted operation (`in_valid` and `ready` high), `out_valid` is high and `product` equals the exact unsigned product of the operands, whatever domains are asleep; otherwise `out_valid` is low and `product` holds its last value.
- R8: A sleeping domain stays asleep across idle cycles and across accepted operations that do not need it.
- R9: Cycles with `in_valid` low neither put an awake domain to sleep nor wake a sleeping one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered on `op_a`/`op_b` |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| ready | output | 1 | High when the offered operation can be accepted this cycle |
| out_valid | output | 1 | `product` carries a fresh result |
| product | output | 2*WIDTH | Unsigned product of the last accepted operation |
| sleep_hi | output | 1 | Sleep control for the hi-by-hi domain |
| sleep_mid | output | 1 | Sleep control for the cross-term domain |
| iso_hi | output | 1 | Output isolation for the hi-by-hi domain |
| iso_mid | output | 1 | Output isolation for the cross-term domain |

## Verification
The operand patterns come in three classes: both upper halves non-zero, exactly one upper half zero, and both upper halves zero. These separate the three sleep sequences, and a wrong narrowness test shows up as a mismatch in the sleep pair. Wide operands offered right after a both-narrow operation show whether the minimum sleep window is honoured and whether the stall lasts exactly through the wake and release cycles. A one-narrow operation offered while both domains sleep must wake only the cross-term domain. Idle stretches and long runs of narrow products confirm that domains stay put without traffic and that isolated domains never corrupt the sum.

// File: rtl/opgate_pkg.sv
package opgate_pkg;
   // phase of one gateable domain
   typedef enum logic [2:0] {
      PH_AWAKE  = 3'd0,
      PH_ENTER  = 3'd1,
      PH_ASLEEP = 3'd2,
      PH_WAKE   = 3'd3,
      PH_EXIT   = 3'd4
   } phase_t;

   // domain indices; hi is only needed when both operands are wide
   localparam int DOM_HI  = 0;
   localparam int DOM_MID = 1;
   localparam int NUM_DOM = 2;
endpackage

// File: rtl/opgate_zdet.sv
module opgate_zdet #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             wide_a,
   output logic             wide_b
);
   localparam int HALF = WIDTH / 2;

   logic [1:0][WIDTH-1:0] ops;
   logic [1:0]            wide;

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar i = 0; i < 2; i++) begin : g_op
      assign wide[i] = |ops[i][WIDTH-1:HALF];
   end

   assign wide_a = wide[0];
   assign wide_b = wide[1];
endmodule

// File: rtl/opgate_domain.sv
module opgate_domain
   import opgate_pkg::*;
#(
   parameter int MIN_SLEEP = 4,
   parameter int WAKE_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic drop,
   output logic sleep_o,
   output logic iso_o,
   output logic avail_o
);
   localparam int LIMIT = (MIN_SLEEP > WAKE_CYC) ? MIN_SLEEP : WAKE_CYC;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] MIN_C  = CW'(MIN_SLEEP);
   localparam logic [CW-1:0] WAKE_C = CW'(WAKE_CYC);
   localparam logic [CW-1:0] ONE_C  = CW'(1);

   phase_t        ph, ph_n;
   logic [CW-1:0] cnt, cnt_n;

   always_comb begin
      ph_n  = ph;
      cnt_n = cnt;
      case (ph)
         PH_AWAKE: begin
            if (drop) ph_n = PH_ENTER;
         end
         PH_ENTER: begin
            ph_n  = PH_ASLEEP;
            cnt_n = ONE_C;
         end
         PH_ASLEEP: begin
            if (want && cnt >= MIN_C) begin
               ph_n  = PH_WAKE;
               cnt_n = ONE_C;
            end else if (cnt < MIN_C) begin
               cnt_n = cnt + ONE_C;
            end
         end
         PH_WAKE: begin
            if (cnt >= WAKE_C) ph_n = PH_EXIT;
            else               cnt_n = cnt + ONE_C;
         end
         PH_EXIT:  ph_n = PH_AWAKE;
         default:  ph_n = PH_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_AWAKE;
         cnt <= '0;
      end else begin
         ph  <= ph_n;
         cnt <= cnt_n;
      end
   end

   assign sleep_o = (ph == PH_ASLEEP);
   assign iso_o   = (ph != PH_AWAKE);
   assign avail_o = (ph == PH_AWAKE);
endmodule

// File: rtl/opgate_array.sv
module opgate_array #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   input  logic               gate_hi,
   input  logic               gate_mid,
   output logic [2*WIDTH-1:0] prod
);
   localparam int HALF = WIDTH / 2;
   localparam int PW   = 2 * WIDTH;

   logic [PW-1:0] a_lo, a_hi, b_lo, b_hi;
   logic [PW-1:0] t_ll, t_cross, t_hh;
   logic [PW-1:0] s_mid, s_hi;

   assign a_lo = PW'(op_a[HALF-1:0]);
   assign a_hi = PW'(op_a[WIDTH-1:HALF]);
   assign b_lo = PW'(op_b[HALF-1:0]);
   assign b_hi = PW'(op_b[WIDTH-1:HALF]);

   // always-on low part
   assign t_ll    = a_lo * b_lo;
   // cross-term domain
   assign t_cross = ((a_lo * b_hi) + (a_hi * b_lo)) << HALF;
   // hi-by-hi domain
   assign t_hh    = (a_hi * b_hi) << WIDTH;

   // isolation clamps a gated domain's output to zero
   assign s_mid = gate_mid ? '0 : t_cross;
   assign s_hi  = gate_hi  ? '0 : t_hh;

   assign prod = t_ll + s_mid + s_hi;
endmodule

// File: rtl/opgate_ctrl.sv
module opgate_ctrl
   import opgate_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int MIN_SLEEP = 4,
   parameter int WAKE_CYC  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   output logic               ready,
   output logic               out_valid,
   output logic [2*WIDTH-1:0] product,
   output logic               sleep_hi,
   output logic               sleep_mid,
   output logic               iso_hi,
   output logic               iso_mid
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("opgate_ctrl: WIDTH must be even and at least 4");
   end
   if (MIN_SLEEP < 1) begin : g_bad_min
      $error("opgate_ctrl: MIN_SLEEP must be at least 1");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("opgate_ctrl: WAKE_CYC must be at least 1");
   end

   logic               wide_a, wide_b;
   logic [NUM_DOM-1:0] need, slp, iso, avail;
   logic               stall, accept;
   logic [PW-1:0]      prod_c;

   opgate_zdet #(.WIDTH(WIDTH)) u_zdet (
      .op_a   (op_a),
      .op_b   (op_b),
      .wide_a (wide_a),
      .wide_b (wide_b)
   );

   assign need[DOM_HI]  = wide_a & wide_b;
   assign need[DOM_MID] = wide_a | wide_b;

   assign stall  = in_valid & (|(need & ~avail));
   assign ready  = ~stall;
   assign accept = in_valid & ~stall;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      opgate_domain #(
         .MIN_SLEEP (MIN_SLEEP),
         .WAKE_CYC  (WAKE_CYC)
      ) u_dom (
         .clk     (clk),
         .rst_n   (rst_n),
         .want    (in_valid & need[d]),
         .drop    (accept & ~need[d]),
         .sleep_o (slp[d]),
         .iso_o   (iso[d]),
         .avail_o (avail[d])
      );
   end

   opgate_array #(.WIDTH(WIDTH)) u_array (
      .op_a     (op_a),
      .op_b     (op_b),
      .gate_hi  (iso[DOM_HI]),
      .gate_mid (iso[DOM_MID]),
      .prod     (prod_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= accept;
         if (accept) product <= prod_c;
      end
   end

   assign sleep_hi  = slp[DOM_HI];
   assign sleep_mid = slp[DOM_MID];
   assign iso_hi    = iso[DOM_HI];
   assign iso_mid   = iso[DOM_MID];
endmodule

// File: rtl/opgate_ctrl_chk.sv
module opgate_ctrl_chk #(
   parameter int WIDTH     = 32,
   parameter int MIN_SLEEP = 4,
   parameter int WAKE_CYC  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [WIDTH-1:0]   op_a,
   input logic [WIDTH-1:0]   op_b,
   input logic               ready,
   input logic               out_valid,
   input logic [2*WIDTH-1:0] product,
   input logic               sleep_hi,
   input logic               sleep_mid,
   input logic               iso_hi,
   input logic               iso_mid
);
   localparam int HALF = WIDTH / 2;
   localparam int PW   = 2 * WIDTH;
   localparam int CW   = $clog2(MIN_SLEEP + 1);

   logic [1:0] slp, iso;
   assign slp = {sleep_mid, sleep_hi};
   assign iso = {iso_mid, iso_hi};

   // R1: state right after reset release
   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sleep_hi && !sleep_mid && !iso_hi && !iso_mid && !out_valid));

   for (genvar d = 0; d < 2; d++) begin : g_chk
      logic [CW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      run <= '0;
         else if (slp[d]) run <= (run < CW'(MIN_SLEEP)) ? run + CW'(1) : run;
         else             run <= '0;
      end

      // R3: isolation leads sleep by one cycle
      assert_iso_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(slp[d]) |-> $past(iso[d]));
      assert_iso_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(iso[d]) |-> !slp[d]);
      // R4: minimum sleep run
      assert_min_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(slp[d]) |-> run >= CW'(MIN_SLEEP));
      // R5: isolation held past the end of sleep
      assert_iso_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(slp[d]) |-> iso[d]);
   end

   // R6: a needed domain that is isolated stalls the offer
   assert_stall_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (|op_a[WIDTH-1:HALF]) && (|op_b[WIDTH-1:HALF]) && iso_hi) |-> !ready);
   assert_stall_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((|op_a[WIDTH-1:HALF]) || (|op_b[WIDTH-1:HALF])) && iso_mid) |-> !ready);

   // R7: result is the exact product of the accepted operands
   assert_product_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (product == (PW'($past(op_a)) * PW'($past(op_b)))));
endmodule

bind opgate_ctrl opgate_ctrl_chk #(
   .WIDTH     (WIDTH),
   .MIN_SLEEP (MIN_SLEEP),
   .WAKE_CYC  (WAKE_CYC)
) u_chk (.*);

// File: tb/opgate_ctrl_test.sv
module opgate_ctrl_test;
   localparam int W     = 32;
   localparam int MINS  = 4;
   localparam int WAKEC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0;
   logic          ready, out_valid;
   logic [2*W-1:0] product;
   logic          sleep_hi, sleep_mid, iso_hi, iso_mid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model: phase per domain 0 awake,1 enter,2 asleep,3 wake,4 exit
   int        mph [2];
   int        mcnt[2];
   bit        m_ov;
   logic [2*W-1:0] m_prod;

   always #4 clk = ~clk;

   opgate_ctrl #(.WIDTH(W), .MIN_SLEEP(MINS), .WAKE_CYC(WAKEC)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .ready(ready), .out_valid(out_valid), .product(product),
      .sleep_hi(sleep_hi), .sleep_mid(sleep_mid), .iso_hi(iso_hi), .iso_mid(iso_mid));

   task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      bit need[2];
      bit e_slp[2], e_iso[2];
      bit e_rdy, acc;
      in_valid = v; op_a = a; op_b = b;
      #1;
      need[0] = (a[W-1:W/2] != 0) && (b[W-1:W/2] != 0);
      need[1] = (a[W-1:W/2] != 0) || (b[W-1:W/2] != 0);
      for (int d = 0; d < 2; d++) begin
         e_slp[d] = (mph[d] == 2);
         e_iso[d] = (mph[d] != 0);
      end
      e_rdy = !(v && ((need[0] && mph[0] != 0) || (need[1] && mph[1] != 0)));
      checks++;
      if (sleep_hi !== e_slp[0] || sleep_mid !== e_slp[1] || iso_hi !== e_iso[0] ||
          iso_mid !== e_iso[1] || ready !== e_rdy || out_valid !== m_ov || product !== m_prod) begin
         errors++;
         $display("FAIL %s t=%0t actual slp=%b%b iso=%b%b rdy=%b ov=%b prod=%h expected slp=%b%b iso=%b%b rdy=%b ov=%b prod=%h",
                  tag, $time, sleep_mid, sleep_hi, iso_mid, iso_hi, ready, out_valid, product,
                  e_slp[1], e_slp[0], e_iso[1], e_iso[0], e_rdy, m_ov, m_prod);
      end
      acc = v && e_rdy;
      for (int d = 0; d < 2; d++) begin
         case (mph[d])
            0: if (acc && !need[d]) mph[d] = 1;
            1: begin mph[d] = 2; mcnt[d] = 1; end
            2: if (v && need[d] && mcnt[d] >= MINS) begin mph[d] = 3; mcnt[d] = 1; end
               else if (mcnt[d] < MINS) mcnt[d]++;
            3: if (mcnt[d] >= WAKEC) mph[d] = 4; else mcnt[d]++;
            default: mph[d] = 0;
         endcase
      end
      m_ov = acc;
      if (acc) m_prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int d = 0; d < 2; d++) begin mph[d] = 0; mcnt[d] = 0; end
      m_ov = 0; m_prod = '0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, "R1");
      step(0, 0, 0, "R1");
      // wide operands keep every domain awake
      step(1, 32'h0001_0002, 32'h0003_0004, "R2");
      step(1, 32'hffff_ffff, 32'hffff_ffff, "R2");
      step(1, 32'h8000_0000, 32'h0001_0000, "R7");
      step(0, 0, 0, "R9");
      step(0, 0, 0, "R9");
      // one narrow operand: only hi sleeps
      step(1, 32'h0000_ffff, 32'h1234_5678, "R2");
      step(0, 0, 0, "R3");
      for (int i = 0; i < 6; i++)
         step(1, 32'h0000_1000 + i, 32'hdead_beef, "R8");
      // both narrow: mid joins
      step(1, 32'h0000_1234, 32'h0000_abcd, "R2");
      step(0, 0, 0, "R3");
      for (int i = 0; i < 3; i++) step(0, 0, 0, "R8");
      // wide operation offered and held until accepted
      for (int i = 0; i < 12; i++) step(1, 32'h8000_0001, 32'hffff_ffff, "R6");
      // minimum sleep window: wide offer right after entry
      step(1, 32'h0000_00ff, 32'h0000_0101, "R2");
      for (int i = 0; i < 14; i++) step(1, 32'h0123_4567, 32'h89ab_cdef, "R4");
      // both asleep, then one-narrow wakes only mid
      step(1, 32'h0000_0003, 32'h0000_0005, "R2");
      for (int i = 0; i < 6; i++) step(0, 0, 0, "R9");
      for (int i = 0; i < 8; i++) step(1, 32'h0000_7777, 32'h0042_0000, "R5");
      for (int i = 0; i < 4; i++) step(0, 0, 0, "R8");
      // mixed traffic
      for (int i = 0; i < 30; i++) begin
         logic [W-1:0] a, b;
         a = (i % 3 == 0) ? 32'h0000_0000 + (i * 97) : 32'h0001_0000 * i + 7;
         b = (i % 4 == 1) ? 32'h0000_ffff : 32'hf000_0000 + i;
         step(1, a, b, "R7");
      end
      for (int i = 0; i < 4; i++) step(0, 0, 0, "R9");
      finish_run();
   end
endmodule